// File: doc/BRIEF.md
# Network Controller Sleep Sequencer

This block moves an Ethernet controller core between normal running and a low-power sleep state. On a sleep request it first stops new frame reception. It then lets receive traffic and pending transmissions drain. It selects the low-power regulator and finally asserts power save. On a wake request it drops power save and waits until both a minimum stabilisation time has passed and the clock-ready flag is set. Only then does it give receive back.

The clock-ready flag is kept inside the block in the power-on reset domain. The controller's ordinary reset leaves it untouched. While power save is high, accesses to the MAC, MII and PHY registers are refused. If the clock never becomes ready within a programmable number of cycles, the block parks in a fault state with receive still off and waits for a new request. A request that arrives while the opposite sequence is running is held and served when that sequence ends.

Top module: `nc_sleep_seq`

## Requirements
- R1: After power-on reset (`por_n` and `rst_n` low), `rx_en` is 1, `lp_reg_sel`, `pwr_save`, `busy` and `wake_fault` are 0, and `clk_ready` is 0.
- R2: A `sleep_req` pulse seen in the running state drops `rx_en` and raises `busy` before any other control output changes.
- R3: After `rx_en` drops, `pwr_save` and `lp_reg_sel` stay 0 while `rx_busy` is 1. After `rx_busy` clears, they stay 0 while `tx_pending` is 1.
- R4: If `lp_reg_sel` is 0 when draining ends, it rises at least one cycle before `pwr_save`. If it is already 1, power save follows without that extra step. Once set, it stays 1 until `rst_n` is asserted.
- R5: While `pwr_save` is 1, `rx_en` is 0 and `mii_acc_gnt` is 0 even when `mii_acc_req` is 1. One cycle after `pwr_save` goes high, `clk_ready` is 0.
- R6: A `wake_req` in sleep drops `pwr_save`. `rx_en` returns to 1 only when `clk_ready` is 1 and at least `MIN_WAKE` cycles have passed in the wake phase.
- R7: `clk_ready` is set one cycle after `osc_stable` is 1 while power save is off. It is cleared by power save or by `por_n`, and asserting only `rst_n` leaves it unchanged.
- R8: If no exit to running happens within `wake_limit` cycles of wake-up (counted from 0 at entry to the wake phase), `wake_fault` goes to 1 with `rx_en` 0 and `pwr_save` 0. A later `wake_req` clears `wake_fault` and retries the wake.
- R9: A `sleep_req` during the wake phase, or a `wake_req` during sleep entry, is held and served after the running sequence ends. A `sleep_req` while asleep and a `wake_req` while running are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | Controller reset, active low, asynchronous |
| sleep_req | input | 1 | Request to enter sleep (pulse) |
| wake_req | input | 1 | Request to leave sleep (pulse) |
| rx_busy | input | 1 | A frame is being received |
| tx_pending | input | 1 | A transmission is requested or running |
| osc_stable | input | 1 | Clock source reports stable |
| wake_limit | input | TW | Wake timeout in cycles |
| mii_acc_req | input | 1 | Request to access MAC/MII/PHY registers |
| rx_en | output | 1 | Receive enable |
| lp_reg_sel | output | 1 | Low-power regulator select |
| pwr_save | output | 1 | Power save control |
| clk_ready | output | 1 | Clock-ready status |
| mii_acc_gnt | output | 1 | Register access granted |
| busy | output | 1 | A sleep or wake sequence is running |
| wake_fault | output | 1 | Wake timed out; receive held off |

## Verification
Two functions can collide in one cycle: a pending request of one kind being served while a request of the other kind lands. Examples are a wake pulse while receive is still draining, and a sleep pulse a few cycles into the wake phase. The bench drives these overlaps directly. A scoreboard judges them by the exact order of control-output snapshots: the held sequence must follow the running one with no snapshot skipped, repeated or added. The discarded cases are judged the same way, because any extra snapshot appears as an unexpected change.

// File: rtl/nss_pkg.sv
package nss_pkg;

   typedef enum logic [2:0] {
      ST_RUN      = 3'd0,
      ST_RX_OFF   = 3'd1,
      ST_TX_DRAIN = 3'd2,
      ST_REG_SET  = 3'd3,
      ST_SLEEP    = 3'd4,
      ST_WAKE     = 3'd5,
      ST_FAULT    = 3'd6
   } nss_state_e;

   localparam int NSS_NREQ  = 2;
   localparam int REQ_SLEEP = 0;
   localparam int REQ_WAKE  = 1;

endpackage

// File: rtl/nss_req_hold.sv
module nss_req_hold #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic [N-1:0] clr,
   output logic [N-1:0] pend
);

   for (genvar i = 0; i < N; i++) begin : g_hold
      logic pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend_q <= 1'b0;
         else        pend_q <= (pend_q & ~clr[i]) | req[i];
      end
      assign pend[i] = pend_q;
   end

endmodule

// File: rtl/nss_wake_timer.sv
module nss_wake_timer #(
   parameter int TW       = 16,
   parameter int MIN_WAKE = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [TW-1:0] limit,
   output logic          min_done,
   output logic          expired
);

   localparam logic [TW-1:0] MIN_V = TW'(MIN_WAKE);
   localparam logic [TW-1:0] SAT_V = {TW{1'b1}};

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run)          cnt_q <= '0;
      else if (cnt_q != SAT_V) cnt_q <= cnt_q + 1'b1;
   end

   assign min_done = (cnt_q >= MIN_V);
   assign expired  = (cnt_q >= limit);

endmodule

// File: rtl/nss_clk_ready.sv
module nss_clk_ready (
   input  logic clk,
   input  logic por_n,
   input  logic pwr_save,
   input  logic osc_stable,
   output logic clk_ready
);

   logic rdy_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)          rdy_q <= 1'b0;
      else if (pwr_save)   rdy_q <= 1'b0;
      else if (osc_stable) rdy_q <= 1'b1;
   end

   assign clk_ready = rdy_q;

endmodule

// File: rtl/nss_fsm.sv
module nss_fsm
   import nss_pkg::*;
#(
   parameter bit SKIP_LP_IF_SET = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_p,
   input  logic wake_p,
   input  logic rx_busy,
   input  logic tx_pending,
   input  logic clk_ready,
   input  logic min_done,
   input  logic expired,
   output logic clr_sleep,
   output logic clr_wake,
   output logic timer_run,
   output logic rx_en,
   output logic lp_sel,
   output logic pwr_save,
   output logic busy,
   output logic fault
);

   nss_state_e state_q, state_d;
   logic       lp_q;
   logic       lp_skip;

   if (SKIP_LP_IF_SET) begin : g_skip
      assign lp_skip = lp_q;
   end else begin : g_always
      assign lp_skip = 1'b0;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:      if (sleep_p) state_d = ST_RX_OFF;
         ST_RX_OFF:   if (!rx_busy) state_d = ST_TX_DRAIN;
         ST_TX_DRAIN: if (!tx_pending) state_d = lp_skip ? ST_SLEEP : ST_REG_SET;
         ST_REG_SET:  state_d = ST_SLEEP;
         ST_SLEEP:    if (wake_p) state_d = ST_WAKE;
         ST_WAKE: begin
            if (clk_ready && min_done) state_d = ST_RUN;
            else if (expired)          state_d = ST_FAULT;
         end
         ST_FAULT: begin
            if (wake_p)       state_d = ST_WAKE;
            else if (sleep_p) state_d = ST_RX_OFF;
         end
         default: state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         lp_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_REG_SET) lp_q <= 1'b1;
      end
   end

   // quiescent states consume or discard held requests
   assign clr_sleep = sleep_p & ((state_q == ST_RUN) | (state_q == ST_SLEEP) |
                                 ((state_q == ST_FAULT) & ~wake_p));
   assign clr_wake  = wake_p  & ((state_q == ST_RUN) | (state_q == ST_SLEEP) |
                                 (state_q == ST_FAULT));

   assign timer_run = (state_q == ST_WAKE);
   assign rx_en     = (state_q == ST_RUN);
   assign pwr_save  = (state_q == ST_SLEEP);
   assign lp_sel    = lp_q | (state_q == ST_REG_SET);
   assign fault     = (state_q == ST_FAULT);
   assign busy      = (state_q == ST_RX_OFF) | (state_q == ST_TX_DRAIN) |
                      (state_q == ST_REG_SET) | (state_q == ST_WAKE);

endmodule

// File: rtl/nc_sleep_seq.sv
module nc_sleep_seq
   import nss_pkg::*;
#(
   parameter int TW             = 16,
   parameter int MIN_WAKE       = 32,
   parameter bit SKIP_LP_IF_SET = 1'b1
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          rst_n,
   input  logic          sleep_req,
   input  logic          wake_req,
   input  logic          rx_busy,
   input  logic          tx_pending,
   input  logic          osc_stable,
   input  logic [TW-1:0] wake_limit,
   input  logic          mii_acc_req,
   output logic          rx_en,
   output logic          lp_reg_sel,
   output logic          pwr_save,
   output logic          clk_ready,
   output logic          mii_acc_gnt,
   output logic          busy,
   output logic          wake_fault
);

   initial begin
      assert (TW >= 4 && TW <= 32) else $fatal(1, "nc_sleep_seq: TW out of range");
      assert (MIN_WAKE >= 1 && MIN_WAKE < (1 << TW))
         else $fatal(1, "nc_sleep_seq: MIN_WAKE does not fit TW");
   end

   logic [NSS_NREQ-1:0] req_v, clr_v, pend_v;
   logic clr_sleep, clr_wake, timer_run, min_done, expired;

   assign req_v[REQ_SLEEP] = sleep_req;
   assign req_v[REQ_WAKE]  = wake_req;
   assign clr_v[REQ_SLEEP] = clr_sleep;
   assign clr_v[REQ_WAKE]  = clr_wake;

   nss_req_hold #(.N(NSS_NREQ)) u_hold (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (req_v),
      .clr  (clr_v),
      .pend (pend_v)
   );

   nss_wake_timer #(.TW(TW), .MIN_WAKE(MIN_WAKE)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (timer_run),
      .limit   (wake_limit),
      .min_done(min_done),
      .expired (expired)
   );

   nss_clk_ready u_rdy (
      .clk       (clk),
      .por_n     (por_n),
      .pwr_save  (pwr_save),
      .osc_stable(osc_stable),
      .clk_ready (clk_ready)
   );

   nss_fsm #(.SKIP_LP_IF_SET(SKIP_LP_IF_SET)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep_p   (pend_v[REQ_SLEEP]),
      .wake_p    (pend_v[REQ_WAKE]),
      .rx_busy   (rx_busy),
      .tx_pending(tx_pending),
      .clk_ready (clk_ready),
      .min_done  (min_done),
      .expired   (expired),
      .clr_sleep (clr_sleep),
      .clr_wake  (clr_wake),
      .timer_run (timer_run),
      .rx_en     (rx_en),
      .lp_sel    (lp_reg_sel),
      .pwr_save  (pwr_save),
      .busy      (busy),
      .fault     (wake_fault)
   );

   assign mii_acc_gnt = mii_acc_req & ~pwr_save;

endmodule

// File: rtl/nss_chk.sv
module nss_chk (
   input logic clk,
   input logic por_n,
   input logic rst_n,
   input logic rx_busy,
   input logic tx_pending,
   input logic rx_en,
   input logic lp_reg_sel,
   input logic pwr_save,
   input logic clk_ready,
   input logic mii_acc_req,
   input logic mii_acc_gnt,
   input logic wake_fault
);

   // R5
   sleep_no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_save |-> (!rx_en && !(mii_acc_gnt && mii_acc_req)));

   // R5
   sleep_clears_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      pwr_save |=> !clk_ready);

   // R4
   lp_before_ps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_save) |-> $past(lp_reg_sel));

   // R4
   lp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(lp_reg_sel));

   // R3
   drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_save) |-> ($past(!tx_pending) && $past(!rx_en)));

   // R6
   rx_after_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_en) |-> clk_ready);

   // R8
   fault_rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_fault |-> (!rx_en && !pwr_save));

endmodule

bind nc_sleep_seq nss_chk u_nss_chk (
   .clk        (clk),
   .por_n      (por_n),
   .rst_n      (rst_n),
   .rx_busy    (rx_busy),
   .tx_pending (tx_pending),
   .rx_en      (rx_en),
   .lp_reg_sel (lp_reg_sel),
   .pwr_save   (pwr_save),
   .clk_ready  (clk_ready),
   .mii_acc_req(mii_acc_req),
   .mii_acc_gnt(mii_acc_gnt),
   .wake_fault (wake_fault)
);

// File: tb/nc_sleep_seq_tb_top.sv
module nc_sleep_seq_tb_top;

   localparam int TW       = 16;
   localparam int MIN_WAKE = 32;

   logic clk = 1'b0;
   logic por_n = 1'b0, rst_n = 1'b0;
   logic sleep_req = 1'b0, wake_req = 1'b0;
   logic rx_busy = 1'b0, tx_pending = 1'b0, osc_stable = 1'b1;
   logic [TW-1:0] wake_limit = 16'd200;
   logic mii_acc_req = 1'b0;
   logic rx_en, lp_reg_sel, pwr_save, clk_ready, mii_acc_gnt, busy, wake_fault;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   nc_sleep_seq #(.TW(TW), .MIN_WAKE(MIN_WAKE)) dut_i (
      .clk(clk), .por_n(por_n), .rst_n(rst_n),
      .sleep_req(sleep_req), .wake_req(wake_req),
      .rx_busy(rx_busy), .tx_pending(tx_pending), .osc_stable(osc_stable),
      .wake_limit(wake_limit), .mii_acc_req(mii_acc_req),
      .rx_en(rx_en), .lp_reg_sel(lp_reg_sel), .pwr_save(pwr_save),
      .clk_ready(clk_ready), .mii_acc_gnt(mii_acc_gnt), .busy(busy),
      .wake_fault(wake_fault)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // snapshot {rx_en, lp_reg_sel, pwr_save, busy, wake_fault}
   localparam logic [4:0] S_RUN0  = 5'b10000;
   localparam logic [4:0] S_RUN1  = 5'b11000;
   localparam logic [4:0] S_OFF0  = 5'b00010;
   localparam logic [4:0] S_BUSY1 = 5'b01010;
   localparam logic [4:0] S_SLEEP = 5'b01100;
   localparam logic [4:0] S_FAULT = 5'b01001;

   logic [4:0] exp_q[$];
   string      tag_q[$];
   logic [4:0] prev_snap;
   bit         mon_on = 1'b0;

   task automatic expect_snap(input logic [4:0] s, input string req);
      exp_q.push_back(s);
      tag_q.push_back(req);
   endtask

   always @(negedge clk) begin
      if (mon_on) begin
         logic [4:0] snap;
         snap = {rx_en, lp_reg_sel, pwr_save, busy, wake_fault};
         if (snap != prev_snap) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R9 unexpected output change", int'(snap), int'(prev_snap));
            end else begin
               logic [4:0] e;
               string      t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(snap == e, t, int'(snap), int'(e));
            end
            prev_snap = snap;
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_sleep();
      @(posedge clk); #1 sleep_req = 1'b1;
      @(posedge clk); #1 sleep_req = 1'b0;
   endtask

   task automatic pulse_wake();
      @(posedge clk); #1 wake_req = 1'b1;
      @(posedge clk); #1 wake_req = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      int wcnt;
      // R1 reset state
      cyc(3);
      chk({rx_en, lp_reg_sel, pwr_save, busy, wake_fault} == S_RUN0, "R1 reset outputs",
          int'({rx_en, lp_reg_sel, pwr_save, busy, wake_fault}), int'(S_RUN0));
      chk(clk_ready == 1'b0, "R1 clk_ready after por", int'(clk_ready), 0);
      @(posedge clk); #1 por_n = 1'b1; rst_n = 1'b1;
      cyc(3);
      chk(clk_ready == 1'b1, "R7 clk_ready sets from osc_stable", int'(clk_ready), 1);
      prev_snap = {rx_en, lp_reg_sel, pwr_save, busy, wake_fault};
      mon_on = 1'b1;

      // R2 R3 R4 R5 first sleep with traffic in flight
      expect_snap(S_OFF0, "R2 receive off first");
      expect_snap(S_BUSY1, "R4 regulator select before power save");
      expect_snap(S_SLEEP, "R5 sleep entered");
      @(posedge clk); #1 rx_busy = 1'b1; tx_pending = 1'b1; mii_acc_req = 1'b1;
      pulse_sleep();
      cyc(20);
      chk(!pwr_save && !lp_reg_sel, "R3 wait on rx_busy", int'({lp_reg_sel, pwr_save}), 0);
      @(posedge clk); #1 rx_busy = 1'b0;
      cyc(10);
      chk(!pwr_save && !lp_reg_sel, "R3 wait on tx_pending", int'({lp_reg_sel, pwr_save}), 0);
      @(posedge clk); #1 tx_pending = 1'b0;
      cyc(5);
      chk(pwr_save == 1'b1, "R4 power save reached", int'(pwr_save), 1);
      chk(clk_ready == 1'b0, "R5 clk_ready cleared in sleep", int'(clk_ready), 0);
      chk(mii_acc_gnt == 1'b0, "R5 register access blocked", int'(mii_acc_gnt), 0);

      // R6 wake respects minimum time and clk_ready
      expect_snap(S_BUSY1, "R6 wake phase");
      expect_snap(S_RUN1, "R6 running again");
      @(posedge clk); #1 osc_stable = 1'b0;
      pulse_wake();
      wcnt = 0;
      fork
         begin cyc(5); @(posedge clk); #1 osc_stable = 1'b1; end
      join_none
      while (!rx_en) begin @(negedge clk); wcnt++; end
      chk(wcnt >= MIN_WAKE, "R6 minimum wake time", wcnt, MIN_WAKE);
      chk(clk_ready == 1'b1, "R6 clk_ready at receive enable", int'(clk_ready), 1);
      chk(mii_acc_gnt == 1'b1, "R5 access granted when awake", int'(mii_acc_gnt), 1);

      // R4 R9 second sleep: regulator already set, wake held during drain
      expect_snap(S_BUSY1, "R9 sleep entry with held wake");
      expect_snap(S_SLEEP, "R4 sleep without regulator step");
      expect_snap(S_BUSY1, "R9 held wake served");
      expect_snap(S_RUN1, "R9 running after held wake");
      @(posedge clk); #1 rx_busy = 1'b1;
      pulse_sleep();
      pulse_wake();
      cyc(8);
      @(posedge clk); #1 rx_busy = 1'b0;
      cyc(3);
      while (!rx_en) @(negedge clk);
      cyc(3);

      // R9 sleep held during wake
      expect_snap(S_OFF0 | 5'b01000, "R9 sleep entry");
      expect_snap(S_SLEEP, "R9 asleep");
      pulse_sleep();
      cyc(6);
      expect_snap(S_BUSY1, "R9 wake phase");
      expect_snap(S_RUN1, "R9 brief run");
      expect_snap(S_BUSY1, "R9 held sleep served");
      expect_snap(S_SLEEP, "R9 asleep after held sleep");
      pulse_wake();
      cyc(3);
      pulse_sleep();
      cyc(MIN_WAKE + 20);
      chk(pwr_save == 1'b1, "R9 held sleep ends asleep", int'(pwr_save), 1);

      // R9 sleep while asleep is discarded
      pulse_sleep();
      cyc(5);
      expect_snap(S_BUSY1, "R9 wake phase");
      expect_snap(S_RUN1, "R9 running, no stale sleep");
      pulse_wake();
      cyc(MIN_WAKE + 20);
      chk(rx_en == 1'b1, "R9 stale sleep discarded", int'(rx_en), 1);

      // R9 wake while running is discarded
      pulse_wake();
      cyc(10);
      expect_snap(S_BUSY1, "R9 sleep entry");
      expect_snap(S_SLEEP, "R9 asleep");
      pulse_sleep();
      cyc(15);
      chk(pwr_save == 1'b1, "R9 stale wake discarded", int'(pwr_save), 1);

      // R8 timeout
      expect_snap(S_BUSY1, "R8 wake phase");
      expect_snap(S_FAULT, "R8 fault raised");
      @(posedge clk); #1 osc_stable = 1'b0; wake_limit = 16'd60;
      pulse_wake();
      cyc(100);
      chk(wake_fault == 1'b1 && rx_en == 1'b0, "R8 fault with receive off",
          int'({wake_fault, rx_en}), 2);

      // R8 retry, R6 waits for late clk_ready
      expect_snap(S_BUSY1, "R8 retry clears fault");
      expect_snap(S_RUN1, "R8 retry reaches run");
      @(posedge clk); #1 wake_limit = 16'd200;
      pulse_wake();
      cyc(50);
      chk(rx_en == 1'b0, "R6 receive held until clk_ready", int'(rx_en), 0);
      @(posedge clk); #1 osc_stable = 1'b1;
      cyc(5);
      chk(rx_en == 1'b1 && wake_fault == 1'b0, "R8 retry result",
          int'({rx_en, wake_fault}), 2);

      // R7 R4 controller reset only
      expect_snap(S_RUN0, "R4 reset clears regulator select");
      @(posedge clk); #1 rst_n = 1'b0;
      cyc(3);
      chk(clk_ready == 1'b1, "R7 clk_ready kept over rst_n", int'(clk_ready), 1);
      chk(lp_reg_sel == 1'b0, "R4 regulator select reset", int'(lp_reg_sel), 0);
      @(posedge clk); #1 rst_n = 1'b1;
      cyc(5);

      chk(exp_q.size() == 0, "R9 all expected snapshots seen", exp_q.size(), 0);
      finish_run();
   end

endmodule